// File: doc/BRIEF.md
# Raster Line Interrupt Generator

This block produces the CPU's maskable interrupt from the line and frame sync pulses of a video timing controller. A 6-bit line counter advances once per line, on the falling edge of HSYNC. Every 52 lines it wraps to zero and raises an interrupt request. With 64 µs lines this gives a 300 Hz rate. The request drives an active-low INT pin and stays asserted until the CPU acknowledges it.

The line counter keeps running while a request is pending. Three things realign it:
- When the CPU acknowledges a pending request, bit 5 of the counter is cleared. The next request therefore cannot follow closer than 32 lines.
- Two lines after a vertical sync begins, the counter is forced back to zero. A request is raised at that point only if the count has not reached 32.
- Software can zero the counter at any time with a single-cycle strobe.

All inputs are synchronous to the clock. Each sync input is compared with a registered copy of itself to find its edges.

Top module: `raster_irq_gen`

## Requirements
- R1: After reset the line counter is 0, no request is pending and `int_no` is high.
- R2: The counter advances by one only in a cycle where `hsync_i` is low and was high in the previous cycle. A steady HSYNC level or a rising HSYNC edge leaves the counter unchanged.
- R3: A line edge that would bring the counter to 52 instead sets it to 0 and raises a request. From a zeroed counter the request therefore follows the 52nd falling HSYNC edge.
- R4: A raised request holds `int_no` low until it is acknowledged. The counter keeps advancing while the request waits.
- R5: Asserting `irq_ack_i` while a request is pending releases `int_no` after that edge and clears bit 5 of the counter. If that cycle also has a line edge, bit 5 is cleared after the increment. An acknowledge with no request pending has no effect on the counter.
- R6: A rising edge of `vsync_i` arms a two-line delay. On the second falling HSYNC edge after it, the counter is set to 0 regardless of its value. A request is raised at that edge only if the incremented count is below 32. A VSYNC that stays high does not re-arm the delay.
- R7: A high `cnt_clr_i` sets the counter to 0 at that edge. It takes priority over a line edge in the same cycle and leaves the request state unchanged.
- R8: If a new request is raised in the same cycle as an acknowledge, the request stays pending and the counter goes to 0.
- R9: `int_no` is active low: 0 means a request is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Line sync from the video timing controller, active high |
| vsync_i | input | 1 | Frame sync from the video timing controller, active high |
| irq_ack_i | input | 1 | CPU interrupt acknowledge, one cycle |
| cnt_clr_i | input | 1 | Software strobe that zeroes the line counter |
| int_no | output | 1 | Interrupt request to the CPU, active low |

## Verification
A falling HSYNC is acted on at the first rising clock edge that samples it low. Any change to `int_no` appears right after that same edge, so every result is due one edge after its stimulus. The bench drives its inputs on the falling clock edge and reads `int_no` on the next falling edge. By then exactly one rising edge has consumed the previous inputs. A reference model in the bench is updated on each rising edge from the requirement rules and is compared every cycle. The directed line counts stop one line before and at the edge where each request is expected.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;
  parameter int CNT_W_DEF    = 6;
  parameter int WRAP_DEF     = 52;
  parameter int TRIM_BIT_DEF = 5;
  parameter int VS_LINES_DEF = 2;
endpackage

// File: rtl/raster_edge_det.sv
module raster_edge_det #(
  parameter int N       = 1,
  parameter bit FALLING = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] edge_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic last_q;
    always_ff @(posedge clk_i) begin
      if (!rst_ni) last_q <= 1'b0;
      else         last_q <= sig_i[g];
    end
    if (FALLING) begin : g_fall
      assign edge_o[g] = last_q & ~sig_i[g];
    end else begin : g_rise
      assign edge_o[g] = ~last_q & sig_i[g];
    end
  end
endmodule

// File: rtl/raster_vs_delay.sv
module raster_vs_delay #(
  parameter int LINES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic step_i,
  output logic due_o
);
  localparam int W = $clog2(LINES + 1);
  logic [W-1:0] wait_q;

  assign due_o = step_i && (wait_q == W'(1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                       wait_q <= '0;
    else if (arm_i)                    wait_q <= W'(LINES);
    else if (step_i && wait_q != '0)   wait_q <= wait_q - 1'b1;
  end

  // R6: the realignment fires once per arming
  p_due_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    due_o |=> !due_o);
endmodule

// File: rtl/raster_line_ctr.sv
module raster_line_ctr #(
  parameter int CNT_W    = 6,
  parameter int WRAP     = 52,
  parameter int TRIM_BIT = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  input  logic vs_due_i,
  input  logic ack_i,
  output logic raise_o
);
  localparam logic [CNT_W-1:0] WRAP_V = CNT_W'(WRAP);
  localparam logic [CNT_W-1:0] THR_V  = CNT_W'(1 << TRIM_BIT);

  logic [CNT_W-1:0] cnt_q, cnt_d, nx;

  always_comb begin
    nx      = cnt_q + 1'b1;
    cnt_d   = cnt_q;
    raise_o = 1'b0;
    if (clear_i) begin
      cnt_d = '0;
    end else if (step_i) begin
      if (nx == WRAP_V) begin
        cnt_d   = '0;
        raise_o = 1'b1;
      end else if (vs_due_i) begin
        cnt_d   = '0;
        raise_o = (nx < THR_V);
      end else begin
        cnt_d = nx;
        if (ack_i) cnt_d[TRIM_BIT] = 1'b0;
      end
    end else if (ack_i) begin
      cnt_d[TRIM_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  p_cnt_below_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < WRAP_V);
  p_wrap_to_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && cnt_q == WRAP_V - 1'b1) |=> cnt_q == '0);
  p_ack_trim_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !clear_i && !step_i) |=> !cnt_q[TRIM_BIT]);
  p_vs_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_due_i && step_i && !clear_i) |=> cnt_q == '0);
  p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);
  p_hold_no_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clear_i && !ack_i) |=> $stable(cnt_q));
endmodule

// File: rtl/raster_irq_latch.sv
module raster_irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raise_i,
  input  logic ack_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      req_q <= 1'b0;
    else if (raise_i) req_q <= 1'b1;
    else if (ack_i)   req_q <= 1'b0;
  end
  assign req_o = req_q;

  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i) |=> req_q);
  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && ack_i && !raise_i) |=> !req_q);
  p_new_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise_i |=> req_q);
endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen
  import raster_irq_pkg::*;
#(
  parameter int CNT_W    = CNT_W_DEF,
  parameter int WRAP     = WRAP_DEF,
  parameter int TRIM_BIT = TRIM_BIT_DEF,
  parameter int VS_LINES = VS_LINES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  input  logic vsync_i,
  input  logic irq_ack_i,
  input  logic cnt_clr_i,
  output logic int_no
);
  logic hs_fall, vs_rise, vs_due, raise, req, ack_eff;

  raster_edge_det #(.N(1), .FALLING(1'b1)) u_hs_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(hsync_i), .edge_o(hs_fall));

  raster_edge_det #(.N(1), .FALLING(1'b0)) u_vs_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(vsync_i), .edge_o(vs_rise));

  raster_vs_delay #(.LINES(VS_LINES)) u_vs_delay (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(vs_rise), .step_i(hs_fall),
    .due_o(vs_due));

  assign ack_eff = irq_ack_i & req;

  raster_line_ctr #(.CNT_W(CNT_W), .WRAP(WRAP), .TRIM_BIT(TRIM_BIT)) u_line_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(cnt_clr_i), .step_i(hs_fall),
    .vs_due_i(vs_due), .ack_i(ack_eff), .raise_o(raise));

  raster_irq_latch u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .raise_i(raise), .ack_i(irq_ack_i),
    .req_o(req));

  assign int_no = ~req;

  // R9: INT low only while a request is pending
  p_int_polarity_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hs_fall && !irq_ack_i) |=> $stable(int_no));
endmodule

// File: tb/test_raster_irq_gen.sv
module test_raster_irq_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs = 1'b0, vs = 1'b0, ack = 1'b0, clr = 1'b0;
  logic int_n;
  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 1'b0;
  logic vs_lvl = 1'b0;
  string phase = "R1";

  always #4 clk = ~clk;

  raster_irq_gen i_raster_irq_gen (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hs), .vsync_i(vs),
    .irq_ack_i(ack), .cnt_clr_i(clr), .int_no(int_n));

  // reference model built from the requirements
  int m_cnt, m_vw;
  logic m_req, m_hq, m_vq;

  function automatic int trim(input int v);
    return v & ~32;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_vw = 0; m_req = 1'b0; m_hq = 1'b0; m_vq = 1'b0;
    end else begin
      logic hf, vr, due, raise, ak;
      int nx;
      hf = m_hq & ~hs;
      vr = ~m_vq & vs;
      due = hf && (m_vw == 1);
      ak = ack && m_req;
      raise = 1'b0;
      if (vr) m_vw = 2;
      else if (hf && m_vw != 0) m_vw = m_vw - 1;
      if (clr) m_cnt = 0;
      else if (hf) begin
        nx = m_cnt + 1;
        if (nx == 52) begin m_cnt = 0; raise = 1'b1; end
        else if (due) begin m_cnt = 0; raise = (nx < 32); end
        else m_cnt = ak ? trim(nx) : nx;
      end else if (ak) m_cnt = trim(m_cnt);
      if (raise) m_req = 1'b1;
      else if (ack) m_req = 1'b0;
      m_hq = hs; m_vq = vs;
    end
  end

  task automatic cmp_model();
    n_cmp++;
    if (int_n !== ~m_req) begin
      n_bad++;
      $display("FAIL %s: int_no actual %b expected %b at %0t", phase, int_n, ~m_req, $time);
    end
  endtask

  task automatic expect_int(input string tag, input logic exp);
    n_cmp++;
    if (int_n !== exp) begin
      n_bad++;
      $display("FAIL %s: int_no actual %b expected %b at %0t", tag, int_n, exp, $time);
    end
  endtask

  task automatic cyc(input logic h, input logic v, input logic a, input logic c);
    @(negedge clk);
    if (rst_n) cmp_model();
    hs = h; vs = v; ack = a; clr = c;
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 3; k++) cyc(1'b1, vs_lvl, 1'b0, 1'b0);
      for (int k = 0; k < 3; k++) cyc(1'b0, vs_lvl, 1'b0, 1'b0);
    end
  endtask

  task automatic pulse_ack();
    cyc(1'b0, vs_lvl, 1'b1, 1'b0);
    cyc(1'b0, vs_lvl, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) @(negedge clk);
    expect_int("R1 reset", 1'b1);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    expect_int("R1 after reset", 1'b1);

    phase = "R2";
    lines(51);  expect_int("R2 51 lines", 1'b1);
    phase = "R3";
    lines(1);   expect_int("R3/R9 52nd line", 1'b0);
    phase = "R4";
    lines(5);   expect_int("R4 held", 1'b0);
    pulse_ack(); expect_int("R5 release", 1'b1);
    lines(46);  expect_int("R4 counting while pending", 1'b1);
    lines(1);   expect_int("R4 counter kept running", 1'b0);

    phase = "R5";
    lines(40);  expect_int("R5 pending", 1'b0);
    pulse_ack(); expect_int("R5 release", 1'b1);
    lines(43);  expect_int("R5 trimmed count 51", 1'b1);
    lines(1);   expect_int("R5 trimmed wrap", 1'b0);
    pulse_ack();
    lines(40);
    pulse_ack(); expect_int("R5 ack ignored", 1'b1);
    lines(11);  expect_int("R5 ack ignored 51", 1'b1);
    lines(1);   expect_int("R5 ack ignored wrap", 1'b0);
    pulse_ack();

    phase = "R6";
    lines(10);
    vs_lvl = 1'b1; cyc(1'b0, 1'b1, 1'b0, 1'b0);
    lines(1);   expect_int("R6 one line after vsync", 1'b1);
    lines(1);   expect_int("R6 low count request", 1'b0);
    vs_lvl = 1'b0;
    pulse_ack();
    lines(51);  expect_int("R6 realigned 51", 1'b1);
    lines(1);   expect_int("R6 realigned wrap", 1'b0);
    pulse_ack();
    lines(35);
    vs_lvl = 1'b1; cyc(1'b0, 1'b1, 1'b0, 1'b0);
    lines(2);   expect_int("R6 high count no request", 1'b1);
    lines(51);  expect_int("R6 steady vsync no rearm", 1'b1);
    lines(1);   expect_int("R6 zeroed wrap", 1'b0);
    vs_lvl = 1'b0;
    pulse_ack();

    phase = "R7";
    lines(30);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    lines(51);  expect_int("R7 cleared 51", 1'b1);
    lines(1);   expect_int("R7 cleared wrap", 1'b0);
    pulse_ack();

    phase = "R8";
    lines(5);
    vs_lvl = 1'b1; cyc(1'b0, 1'b1, 1'b0, 1'b0);
    lines(2);
    vs_lvl = 1'b0;
    lines(51);  expect_int("R8 pending at 51", 1'b0);
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    expect_int("R8 new request beats ack", 1'b0);
    pulse_ack(); expect_int("R8 later release", 1'b1);

    phase = "R2-random";
    begin
      logic h, v;
      h = 1'b0; v = 1'b0;
      for (int i = 0; i < 6000; i++) begin
        logic a, c;
        if ($urandom % 4 == 0) h = ~h;
        if ($urandom % 250 == 0) v = ~v;
        a = ((int_n == 1'b0) && ($urandom % 10 == 0)) || ($urandom % 80 == 0);
        c = ($urandom % 400 == 0);
        cyc(h, v, a, c);
      end
    end
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    finish_run();
  end
endmodule